// File: doc/BRIEF.md
# Delay-Line TDC Timestamp Core

This block is the digital back end of a time-to-digital converter built on a tapped delay line. On every clock edge it registers the full tap vector of the line. It detects a new edge by comparing tap 0 with the value tap 0 held one clock earlier. It then locates the edge front inside the snapshot and stamps it with a free-running binary clock count. The fine position is the bin within the line, and the count is the coarse time. One event record is produced for each detected edge.

The line is longer than one clock period, so an edge usually still sits inside the line at the next clock edge, further along. The block holds each event for one extra clock. If the next snapshot still shows the same edge, the block attaches that second position to the record. The second position minus the first gives the clock period expressed in bins. Downstream logic uses this value to track the average bin width as supply voltage and temperature drift. Rising and falling edges are handled alike. Bubbles in the thermometer pattern beyond the edge front are ignored.

Top module: `tdc_stamp_core`

## Requirements
- R1: While `rst` is high (synchronous, active high), all outputs are zero. The first snapshot after reset is compared against a tap 0 value of 0.
- R2: The record for a snapshot captured at clock edge k is presented, with `ev_valid_o` high, after clock edge k+2. `ev_valid_o` is high for exactly one cycle per event.
- R3: A snapshot is a hit when its tap 0 differs from tap 0 of the previous snapshot. A rise (0 to 1) and a fall (1 to 0) both count. For a fall, the snapshot is bit-inverted before it is encoded.
- R4: The fine code is the index of the lowest tap whose value differs from tap 0, after the polarity fold. Taps above that index are ignored, so bubbles have no effect. The fine code lies in 1..TAPS-1.
- R5: A hit whose snapshot is uniform (all taps equal) produces no record.
- R6: The coarse field equals the number of clock edges since reset release at the capture edge k, modulo 2^CW. It wraps with no special handling, so back-to-back events carry consecutive coarse values.
- R7: If the snapshot after a hit has the same tap 0 and is not uniform, the record sets `ev_fine2_ok_o`. `ev_fine2_o` then carries that snapshot's boundary index, found by the R4 rule with the same polarity.
- R8: If the following snapshot is itself a hit, or is uniform, `ev_fine2_ok_o` is 0 and `ev_fine2_o` is 0. A hit in that next snapshot still produces its own record, so the dead time is one clock.
- R9: In any cycle with `ev_valid_o` low, the coarse, fine and flag outputs are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; taps are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| taps_i | input | TAPS | Raw tap vector of the delay line, bit 0 nearest the line input |
| ev_valid_o | output | 1 | One-cycle event strobe |
| ev_coarse_o | output | CW | Coarse clock count at capture |
| ev_fine1_o | output | $clog2(TAPS) | Edge position in the capturing snapshot |
| ev_fine2_o | output | $clog2(TAPS) | Edge position one clock later |
| ev_fine2_ok_o | output | 1 | Second position present |

## Verification
Each failure mode below shows up directly in the event stream.

- **Falling edges.** The bench drives both polarities. A design that skipped the inversion would either miss falling edges or report tap 0 as the edge.
- **Bubbles.** Random bubbles above the edge front would move the fine code in a design that encoded the highest transition rather than the lowest.
- **Uniform snapshots.** All-ones and all-zeros patterns arriving while tap 0 toggles would emit spurious records if the uniform case were not suppressed.
- **Back-to-back hits.** Consecutive hits check that the second code is withheld when a new edge enters, while the new edge still gets its own record.
- **Coarse wrap.** The coarse counter is driven through several wraps. An off-by-one capture cycle would show as a coarse field shifted by one against the model.

// File: rtl/tdc_stamp_pkg.sv
package tdc_stamp_pkg;
    // Default geometry of the delay line and coarse counter
    localparam int TDC_TAPS_DEF   = 32;
    localparam int TDC_COARSE_DEF = 8;
endpackage

// File: rtl/tdc_tap_capture.sv
module tdc_tap_capture #(
    parameter int TAPS = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [TAPS-1:0] taps_i,
    output logic [TAPS-1:0] snap_o,
    output logic            prev_tap0_o
);
    typedef struct packed {
        logic [TAPS-1:0] snap;
        logic            prev0;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d       = cap_q;
        cap_d.snap  = taps_i;
        cap_d.prev0 = cap_q.snap[0];
    end

    always_ff @(posedge clk) begin
        if (rst) cap_q <= '0;
        else     cap_q <= cap_d;
    end

    assign snap_o      = cap_q.snap;
    assign prev_tap0_o = cap_q.prev0;
endmodule

// File: rtl/tdc_edge_encoder.sv
module tdc_edge_encoder #(
    parameter int TAPS = 32,
    parameter int FW   = $clog2(TAPS)
) (
    input  logic [TAPS-1:0] snap_i,
    output logic            found_o,
    output logic [FW-1:0]   pos_o
);
    // Fold polarity so that tap 0 always reads as 1
    logic [TAPS-1:0] norm;
    logic [TAPS-1:0] run;     // run[i]: taps 0..i-1 all still 1
    logic [TAPS-1:0] front;   // one-hot at the first 0 above tap 0

    assign norm = snap_i ^ {TAPS{~snap_i[0]}};
    assign run[0] = 1'b1;

    genvar gi;
    generate
        for (gi = 1; gi < TAPS; gi++) begin : g_run
            assign run[gi] = run[gi-1] & norm[gi-1];
        end
        for (gi = 0; gi < TAPS; gi++) begin : g_front
            assign front[gi] = run[gi] & ~norm[gi];
        end
    endgenerate

    always_comb begin
        found_o = |front;
        pos_o   = '0;
        for (int i = 1; i < TAPS; i++) begin
            if (front[i]) pos_o = pos_o | FW'(i);
        end
    end
endmodule

// File: rtl/tdc_coarse_counter.sv
module tdc_coarse_counter #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    output logic [CW-1:0] count_o
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q + CW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign count_o = cnt_q;
endmodule

// File: rtl/tdc_stamp_core.sv
module tdc_stamp_core
    import tdc_stamp_pkg::*;
#(
    parameter  int TAPS = TDC_TAPS_DEF,
    parameter  int CW   = TDC_COARSE_DEF,
    localparam int FW   = $clog2(TAPS)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [TAPS-1:0] taps_i,
    output logic            ev_valid_o,
    output logic [CW-1:0]   ev_coarse_o,
    output logic [FW-1:0]   ev_fine1_o,
    output logic [FW-1:0]   ev_fine2_o,
    output logic            ev_fine2_ok_o
);
    typedef struct packed {
        logic          pend_vld;
        logic [CW-1:0] pend_coarse;
        logic [FW-1:0] pend_fine;
        logic          out_vld;
        logic [CW-1:0] out_coarse;
        logic [FW-1:0] out_fine1;
        logic [FW-1:0] out_fine2;
        logic          out_f2ok;
    } core_t;

    core_t st_d, st_q;

    logic [TAPS-1:0] snap;
    logic            prev0;
    logic            found;
    logic [FW-1:0]   pos;
    logic [CW-1:0]   coarse;
    logic            hit;

    tdc_tap_capture #(.TAPS(TAPS)) u_capture (
        .clk         (clk),
        .rst         (rst),
        .taps_i      (taps_i),
        .snap_o      (snap),
        .prev_tap0_o (prev0)
    );

    tdc_edge_encoder #(.TAPS(TAPS), .FW(FW)) u_encoder (
        .snap_i  (snap),
        .found_o (found),
        .pos_o   (pos)
    );

    tdc_coarse_counter #(.CW(CW)) u_coarse (
        .clk     (clk),
        .rst     (rst),
        .count_o (coarse)
    );

    assign hit = snap[0] ^ prev0;

    always_comb begin
        st_d = '0;
        // Stage 1: open a pending event on a new, non-uniform edge
        if (hit && found) begin
            st_d.pend_vld    = 1'b1;
            st_d.pend_coarse = coarse;
            st_d.pend_fine   = pos;
        end
        // Stage 2: close the pending event with the follow-up snapshot
        if (st_q.pend_vld) begin
            st_d.out_vld    = 1'b1;
            st_d.out_coarse = st_q.pend_coarse;
            st_d.out_fine1  = st_q.pend_fine;
            if (!hit && found) begin
                st_d.out_f2ok  = 1'b1;
                st_d.out_fine2 = pos;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign ev_valid_o    = st_q.out_vld;
    assign ev_coarse_o   = st_q.out_coarse;
    assign ev_fine1_o    = st_q.out_fine1;
    assign ev_fine2_o    = st_q.out_fine2;
    assign ev_fine2_ok_o = st_q.out_f2ok;
endmodule

// File: rtl/tdc_stamp_chk.sv
module tdc_stamp_chk #(
    parameter int CW = 8,
    parameter int FW = 5
) (
    input logic          clk,
    input logic          rst,
    input logic          ev_valid_o,
    input logic [CW-1:0] ev_coarse_o,
    input logic [FW-1:0] ev_fine1_o,
    input logic [FW-1:0] ev_fine2_o,
    input logic          ev_fine2_ok_o
);
    p_idle_zero_r9: assert property (@(posedge clk) disable iff (rst)
        !ev_valid_o |-> (ev_coarse_o == '0 && ev_fine1_o == '0 &&
                         ev_fine2_o == '0 && !ev_fine2_ok_o));

    p_fine1_range_r4: assert property (@(posedge clk) disable iff (rst)
        ev_valid_o |-> ev_fine1_o != '0);

    p_fine2_absent_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (ev_valid_o && !ev_fine2_ok_o) |-> ev_fine2_o == '0);

    p_fine2_present_nonzero_r7: assert property (@(posedge clk) disable iff (rst)
        ev_fine2_ok_o |-> (ev_valid_o && ev_fine2_o != '0));

    p_coarse_step_r6: assert property (@(posedge clk) disable iff (rst)
        (ev_valid_o && $past(ev_valid_o)) |-> ev_coarse_o == CW'($past(ev_coarse_o) + CW'(1)));
endmodule

bind tdc_stamp_core tdc_stamp_chk #(.CW(CW), .FW(FW)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .ev_valid_o    (ev_valid_o),
    .ev_coarse_o   (ev_coarse_o),
    .ev_fine1_o    (ev_fine1_o),
    .ev_fine2_o    (ev_fine2_o),
    .ev_fine2_ok_o (ev_fine2_ok_o)
);

// File: tb/tdc_stamp_core_bench.sv
module tdc_stamp_core_bench;
    localparam int PERIOD = 10;
    localparam int TAPS   = 32;
    localparam int CW     = 8;
    localparam int FW     = $clog2(TAPS);
    localparam int NRAND  = 1500;
    localparam int HMAX   = 2048;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [TAPS-1:0] taps_i = '0;
    logic            ev_valid_o;
    logic [CW-1:0]   ev_coarse_o;
    logic [FW-1:0]   ev_fine1_o;
    logic [FW-1:0]   ev_fine2_o;
    logic            ev_fine2_ok_o;

    int checks = 0;
    int errors = 0;
    int n = 0;
    logic [TAPS-1:0] hist [HMAX];

    always #(PERIOD/2) clk = ~clk;

    tdc_stamp_core #(.TAPS(TAPS), .CW(CW)) u_tdc_stamp_core (
        .clk           (clk),
        .rst           (rst),
        .taps_i        (taps_i),
        .ev_valid_o    (ev_valid_o),
        .ev_coarse_o   (ev_coarse_o),
        .ev_fine1_o    (ev_fine1_o),
        .ev_fine2_o    (ev_fine2_o),
        .ev_fine2_ok_o (ev_fine2_ok_o)
    );

    // Boundary per the requirements: lowest tap differing from tap 0
    function automatic void bnd(input logic [TAPS-1:0] p, output logic f,
                                output logic [FW-1:0] pos);
        f   = 1'b0;
        pos = '0;
        for (int i = TAPS-1; i >= 1; i--) begin
            if (p[i] != p[0]) begin
                f   = 1'b1;
                pos = FW'(i);
            end
        end
    endfunction

    function automatic logic [TAPS-1:0] mkpat(input logic b, input int p, input logic bub);
        logic [TAPS-1:0] nm;
        nm = '0;
        for (int i = 0; i < TAPS; i++) begin
            if (i < p) nm[i] = 1'b1;
            else if (i > p && bub) nm[i] = 1'($urandom % 2);
        end
        return b ? nm : ~nm;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s at cycle %0d: actual %0h expected %0h", tag, n, act, exp);
        end
    endtask

    task automatic check_out();
        logic e_vld, e_f2ok, f1, f2, h1, h2;
        logic [FW-1:0] p1, p2;
        int k;
        e_vld = 1'b0; e_f2ok = 1'b0; p1 = '0; p2 = '0; h1 = 1'b0; f1 = 1'b0;
        if (n >= 3) begin
            k  = n - 2;
            h1 = hist[k][0] != hist[k-1][0];
            bnd(hist[k], f1, p1);
            e_vld = h1 && f1;
            h2 = hist[k+1][0] != hist[k][0];
            bnd(hist[k+1], f2, p2);
            e_f2ok = !h2 && f2;
            if (!e_f2ok) p2 = '0;
        end
        if (h1 && !f1) chk("R5 uniform hit gives no record", 32'(ev_valid_o), 32'(e_vld));
        else           chk("R2 R3 valid strobe", 32'(ev_valid_o), 32'(e_vld));
        if (e_vld) begin
            chk("R6 coarse", 32'(ev_coarse_o), 32'((n - 2) % (1 << CW)));
            chk("R4 fine1", 32'(ev_fine1_o), 32'(p1));
            chk("R7 fine2 flag", 32'(ev_fine2_ok_o), 32'(e_f2ok));
            chk("R8 fine2 value", 32'(ev_fine2_o), 32'(p2));
        end else begin
            chk("R9 idle fields zero",
                32'({ev_coarse_o, ev_fine1_o, ev_fine2_o, ev_fine2_ok_o}), 32'd0);
        end
    endtask

    task automatic cyc(input logic [TAPS-1:0] pat);
        taps_i    = pat;
        hist[n+1] = pat;
        @(posedge clk);
        n++;
        @(negedge clk);
        check_out();
    endtask

    initial begin
        void'($urandom(32'd1234));
        hist[0] = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 reset outputs", 32'({ev_valid_o, ev_coarse_o, ev_fine1_o,
                                      ev_fine2_o, ev_fine2_ok_o}), 32'd0);
        taps_i = '1;
        @(negedge clk);
        chk("R1 outputs held in reset", 32'(ev_valid_o), 32'd0);
        taps_i = '0;
        rst = 1'b0;

        // Directed: rising edge seen twice (R7), fine1 5 and fine2 18
        cyc('0);
        cyc(32'h0000_001F);
        cyc(32'h0003_FFFF);
        cyc('1);
        cyc('1);
        // Falling edge (R3), then an immediate new rise (R8), then uniform (R5)
        cyc(32'hFFFF_FF80);
        cyc(32'h0000_0003);
        cyc('0);
        cyc('1);
        cyc('0);
        // Bubble above the front (R4): fine1 3
        cyc(32'h0000_00A7);
        cyc(32'h0000_0A7F);
        cyc('0);

        // Random mix, long enough to wrap the coarse count (R6)
        for (int i = 0; i < NRAND; i++) begin
            cyc(mkpat(1'($urandom % 2), 1 + int'($urandom % TAPS), ($urandom % 4) == 0));
        end
        repeat (4) cyc('0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired at cycle %0d", n);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule